// File: doc/BRIEF.md
# Shuffle Buffer Address Swapper

This block keeps an observer of the external address bus from learning which blocks are used again. A small on-chip buffer always holds a fixed number of logical blocks. The rest of the logical blocks each sit in one physical memory slot. A lookup of a block that is already in the buffer is served on chip and causes no bus traffic. A request for a block that lives in memory becomes a read of its slot. The read is followed at once by a write to that same slot. The write stores a block picked pseudo-randomly from the buffer, and the requested block takes over the buffer entry that the outgoing block left.

Because of this, the bus only ever shows read/write pairs to one address. A block changes its physical location each time it crosses the bus. The remap table tracks where every logical block currently lives. It can be queried at any time through a separate combinational lookup port. At reset, logical blocks `0 .. NUM_SLOTS-1` occupy the slots with the same number. Blocks `NUM_SLOTS .. NUM_SLOTS+BUF_DEPTH-1` fill the buffer entries `0 .. BUF_DEPTH-1` in order.

Top module: `shuffle_swapper`

## Requirements
- R1: After reset, the lookup port reports logical block i (i < NUM_SLOTS) as `lk_in_buf=0`, `lk_loc=i`, and block NUM_SLOTS+j as `lk_in_buf=1`, `lk_loc=j`. `req_ready` is 1, and `mem_rd_en`, `mem_wr_en` and `done_valid` are 0.
- R2: An accepted request for a block whose lookup shows `in_buf=1` gives `done_valid=1` with `done_hit=1` in the next cycle. It gives no `mem_rd_en` or `mem_wr_en` pulse, and every lookup result stays unchanged.
- R3: An accepted request for a block stored in slot s gives `mem_rd_en=1` with `mem_slot=s` in the next cycle. The cycle after that gives `mem_wr_en=1` with `mem_slot=s`, together with `done_valid=1` and `done_hit=0`. A write is never issued without a read of the same slot in the cycle before it.
- R4: The block named on `mem_wr_lblk` during a write was in the buffer before the request. It is not the requested block, and it does not occupy the buffer entry filled by the previous miss.
- R5: From the cycle after the write, the lookup port shows the requested block with `in_buf=1` at the buffer entry the written-back block had held. It shows the written-back block with `in_buf=0` at slot s.
- R6: `req_ready` is 0 in every cycle in which a request is being served (read cycle, write cycle or hit response) and 1 otherwise.
- R7: A request whose logical block number is NUM_SLOTS+BUF_DEPTH or more is dropped. It causes no bus command and no `done_valid`, and `req_ready` stays 1.
- R8: `mem_rd_en` and `mem_wr_en` are never 1 in the same cycle, and every read is followed by a write in the next cycle.
- R9: At all times each slot holds exactly one logical block and each buffer entry holds exactly one logical block.
- R10: Victims are chosen by an 8-bit pseudo-random sequence reduced modulo BUF_DEPTH. Over a run of 40 misses, at least three different buffer entries give up a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_lblk | input | LBW | Logical block requested |
| req_ready | output | 1 | Block idle and able to take a request |
| done_valid | output | 1 | Request finished this cycle |
| done_hit | output | 1 | Finished request was served from the buffer |
| mem_rd_en | output | 1 | Memory read command |
| mem_wr_en | output | 1 | Memory write command |
| mem_slot | output | SW | Physical slot for the read or write |
| mem_wr_lblk | output | LBW | Logical block carried by the write |
| lk_lblk | input | LBW | Logical block to look up |
| lk_in_buf | output | 1 | Looked-up block is in the buffer |
| lk_loc | output | LOCW | Slot number or buffer entry of the looked-up block |

## Verification
The swap is tried in several ways. One pattern sends repeated misses to blocks that start in their reset slots. Another re-requests blocks that were just written back, which shows the table really moved them rather than leaving them in place. A third sends hits to blocks just pulled into the buffer, which separates a buffer hit from a bus access. A long run of misses checks that the victim changes from miss to miss and never lands on the entry just filled. After every swap, the whole lookup port is swept against an independent model to confirm the one-to-one placement. Out-of-range block numbers check that the request filter drops them.

// File: rtl/shuffle_swapper_pkg.sv
package shuffle_swapper_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } sw_state_e;

    localparam int unsigned DEF_SLOTS = 16;
    localparam int unsigned DEF_DEPTH = 8;

endpackage

// File: rtl/shuffle_lfsr.sv
module shuffle_lfsr #(
    parameter int unsigned    WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'hB8,
    parameter logic [WIDTH-1:0] SEED = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (step) begin
            lfsr_d = lfsr_q >> 1;
            if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

endmodule

// File: rtl/shuffle_victim_pick.sv
module shuffle_victim_pick #(
    parameter int unsigned RW    = 8,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [RW-1:0] rnd,
    input  logic          last_vld,
    input  logic [IW-1:0] last_idx,
    output logic [IW-1:0] pick
);

    logic [IW-1:0] raw;
    logic [IW-1:0] bumped;

    always_comb begin
        raw    = IW'(rnd % RW'(DEPTH));
        bumped = (raw == IW'(DEPTH - 1)) ? '0 : raw + 1'b1;
        pick   = (last_vld && raw == last_idx) ? bumped : raw;
    end

endmodule

// File: rtl/shuffle_remap_table.sv
module shuffle_remap_table #(
    parameter int unsigned SLOTS = 16,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned NLB   = SLOTS + DEPTH,
    parameter int unsigned LBW   = $clog2(NLB),
    parameter int unsigned SW    = $clog2(SLOTS),
    parameter int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int unsigned LOCW  = (SW > IW) ? SW : IW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LBW-1:0]  a_lblk,
    output logic            a_in_buf,
    output logic [LOCW-1:0] a_loc,
    input  logic [LBW-1:0]  b_lblk,
    output logic            b_in_buf,
    output logic [LOCW-1:0] b_loc,
    input  logic [IW-1:0]   v_idx,
    output logic [LBW-1:0]  v_lblk,
    input  logic            commit,
    input  logic [LBW-1:0]  c_lblk,
    input  logic [SW-1:0]   c_slot,
    input  logic [IW-1:0]   c_idx
);

    typedef struct packed {
        logic            in_buf;
        logic [LOCW-1:0] loc;
    } ent_t;

    typedef struct packed {
        ent_t [NLB-1:0]             map;
        logic [DEPTH-1:0][LBW-1:0]  bufl;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    function automatic tbl_t tbl_init();
        tbl_t t;
        t = '0;
        for (int i = 0; i < int'(SLOTS); i++) begin
            t.map[i].in_buf = 1'b0;
            t.map[i].loc    = LOCW'(i);
        end
        for (int j = 0; j < int'(DEPTH); j++) begin
            t.map[SLOTS + j].in_buf = 1'b1;
            t.map[SLOTS + j].loc    = LOCW'(j);
            t.bufl[j]               = LBW'(SLOTS + j);
        end
        return t;
    endfunction

    // read ports, guarded against out-of-range block numbers
    always_comb begin
        a_in_buf = 1'b0;
        a_loc    = '0;
        b_in_buf = 1'b0;
        b_loc    = '0;
        if (32'(a_lblk) < NLB) begin
            a_in_buf = tbl_q.map[a_lblk].in_buf;
            a_loc    = tbl_q.map[a_lblk].loc;
        end
        if (32'(b_lblk) < NLB) begin
            b_in_buf = tbl_q.map[b_lblk].in_buf;
            b_loc    = tbl_q.map[b_lblk].loc;
        end
        v_lblk = tbl_q.bufl[v_idx];
    end

    // swap: outgoing block to the slot, incoming block to the freed entry
    always_comb begin
        logic [LBW-1:0] outgoing;
        tbl_d    = tbl_q;
        outgoing = tbl_q.bufl[c_idx];
        if (commit) begin
            tbl_d.map[outgoing].in_buf = 1'b0;
            tbl_d.map[outgoing].loc    = LOCW'(c_slot);
            tbl_d.map[c_lblk].in_buf   = 1'b1;
            tbl_d.map[c_lblk].loc      = LOCW'(c_idx);
            tbl_d.bufl[c_idx]          = c_lblk;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= tbl_init();
        else        tbl_q <= tbl_d;
    end

endmodule

// File: rtl/shuffle_swapper.sv
module shuffle_swapper
    import shuffle_swapper_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned NLB   = SLOTS + DEPTH,
    parameter int unsigned LBW   = $clog2(NLB),
    parameter int unsigned SW    = $clog2(SLOTS),
    parameter int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int unsigned LOCW  = (SW > IW) ? SW : IW,
    parameter int unsigned RW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [LBW-1:0]  req_lblk,
    output logic            req_ready,
    output logic            done_valid,
    output logic            done_hit,
    output logic            mem_rd_en,
    output logic            mem_wr_en,
    output logic [SW-1:0]   mem_slot,
    output logic [LBW-1:0]  mem_wr_lblk,
    input  logic [LBW-1:0]  lk_lblk,
    output logic            lk_in_buf,
    output logic [LOCW-1:0] lk_loc
);

    typedef struct packed {
        sw_state_e      st;
        logic [LBW-1:0] lblk;
        logic [SW-1:0]  slot;
        logic [IW-1:0]  vidx;
        logic [IW-1:0]  last;
        logic           last_vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            a_in_buf;
    logic [LOCW-1:0] a_loc;
    logic [RW-1:0]   rnd;
    logic [IW-1:0]   pick;
    logic [LBW-1:0]  v_lblk;
    logic            commit;
    logic            accept;

    assign accept = req_valid && (ctl_q.st == ST_IDLE) && (32'(req_lblk) < NLB);
    assign commit = (ctl_q.st == ST_WR);

    shuffle_lfsr #(
        .WIDTH (RW),
        .TAPS  (RW'(8'hB8)),
        .SEED  (RW'(8'h5A))
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ctl_q.st == ST_RD),
        .value (rnd)
    );

    shuffle_victim_pick #(
        .RW    (RW),
        .DEPTH (DEPTH),
        .IW    (IW)
    ) u_pick (
        .rnd      (rnd),
        .last_vld (ctl_q.last_vld),
        .last_idx (ctl_q.last),
        .pick     (pick)
    );

    shuffle_remap_table #(
        .SLOTS (SLOTS),
        .DEPTH (DEPTH),
        .NLB   (NLB),
        .LBW   (LBW),
        .SW    (SW),
        .IW    (IW),
        .LOCW  (LOCW)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_lblk   (req_lblk),
        .a_in_buf (a_in_buf),
        .a_loc    (a_loc),
        .b_lblk   (lk_lblk),
        .b_in_buf (lk_in_buf),
        .b_loc    (lk_loc),
        .v_idx    (ctl_q.vidx),
        .v_lblk   (v_lblk),
        .commit   (commit),
        .c_lblk   (ctl_q.lblk),
        .c_slot   (ctl_q.slot),
        .c_idx    (ctl_q.vidx)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.lblk = req_lblk;
                    ctl_d.slot = SW'(a_loc);
                    ctl_d.st   = a_in_buf ? ST_HIT : ST_RD;
                end
            end
            ST_HIT: ctl_d.st = ST_IDLE;
            ST_RD: begin
                ctl_d.vidx = pick;
                ctl_d.st   = ST_WR;
            end
            ST_WR: begin
                ctl_d.last     = ctl_q.vidx;
                ctl_d.last_vld = 1'b1;
                ctl_d.st       = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.st == ST_IDLE);
    assign done_valid  = (ctl_q.st == ST_HIT) || (ctl_q.st == ST_WR);
    assign done_hit    = (ctl_q.st == ST_HIT);
    assign mem_rd_en   = (ctl_q.st == ST_RD);
    assign mem_wr_en   = (ctl_q.st == ST_WR);
    assign mem_slot    = ctl_q.slot;
    assign mem_wr_lblk = (ctl_q.st == ST_WR) ? v_lblk : '0;

endmodule

// File: rtl/shuffle_swapper_chk.sv
module shuffle_swapper_chk #(
    parameter int unsigned NLB = 24,
    parameter int unsigned LBW = 5,
    parameter int unsigned SW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [LBW-1:0] req_lblk,
    input logic           req_ready,
    input logic           done_valid,
    input logic           done_hit,
    input logic           mem_rd_en,
    input logic           mem_wr_en,
    input logic [SW-1:0]  mem_slot,
    input logic [LBW-1:0] mem_wr_lblk,
    input logic [LBW-1:0] cur_lblk
);

    assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_rd_then_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    assert_wr_same_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && mem_slot == $past(mem_slot)));

    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en || done_valid) |-> !req_ready);

    assert_hit_no_traffic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_hit) |-> (!mem_rd_en && !mem_wr_en));

    assert_victim_not_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_lblk != cur_lblk));

    assert_oob_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && 32'(req_lblk) >= NLB) |=> (req_ready && !done_valid));

endmodule

bind shuffle_swapper shuffle_swapper_chk #(
    .NLB (NLB),
    .LBW (LBW),
    .SW  (SW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_lblk    (req_lblk),
    .req_ready   (req_ready),
    .done_valid  (done_valid),
    .done_hit    (done_hit),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_slot    (mem_slot),
    .mem_wr_lblk (mem_wr_lblk),
    .cur_lblk    (ctl_q.lblk)
);

// File: tb/shuffle_swapper_tb.sv
`timescale 1ns/1ps
module shuffle_swapper_tb;

    localparam int SLOTS = 16;
    localparam int DEPTH = 8;
    localparam int NLB   = SLOTS + DEPTH;
    localparam int LBW   = $clog2(NLB);
    localparam int SW    = $clog2(SLOTS);
    localparam int IW    = $clog2(DEPTH);
    localparam int LOCW  = (SW > IW) ? SW : IW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [LBW-1:0]  req_lblk = '0;
    logic            req_ready, done_valid, done_hit;
    logic            mem_rd_en, mem_wr_en;
    logic [SW-1:0]   mem_slot;
    logic [LBW-1:0]  mem_wr_lblk;
    logic [LBW-1:0]  lk_lblk = '0;
    logic            lk_in_buf;
    logic [LOCW-1:0] lk_loc;

    int n_run = 0;
    int n_fail = 0;

    // bench model of the placement
    bit bm_in_buf [NLB];
    int bm_loc    [NLB];
    int last_ent  = -1;
    bit used_ent  [DEPTH];

    always #2.5 clk = ~clk;

    shuffle_swapper u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_lblk (req_lblk), .req_ready (req_ready),
        .done_valid (done_valid), .done_hit (done_hit),
        .mem_rd_en (mem_rd_en), .mem_wr_en (mem_wr_en),
        .mem_slot (mem_slot), .mem_wr_lblk (mem_wr_lblk),
        .lk_lblk (lk_lblk), .lk_in_buf (lk_in_buf), .lk_loc (lk_loc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

    // full sweep of the lookup port against the model, plus one-to-one check
    task automatic sweep(input string req);
        int slot_cnt [SLOTS];
        int ent_cnt  [DEPTH];
        int bad;
        bad = 0;
        for (int s = 0; s < SLOTS; s++) slot_cnt[s] = 0;
        for (int e = 0; e < DEPTH; e++) ent_cnt[e] = 0;
        for (int i = 0; i < NLB; i++) begin
            lk_lblk = LBW'(i);
            #0.5;
            if (lk_in_buf !== bm_in_buf[i] || int'(lk_loc) != bm_loc[i]) bad++;
            if (lk_in_buf) ent_cnt[lk_loc]++; else slot_cnt[lk_loc]++;
        end
        check(bad == 0, req, "lookup entries differing from model", bad, 0);
        bad = 0;
        for (int s = 0; s < SLOTS; s++) if (slot_cnt[s] != 1) bad++;
        for (int e = 0; e < DEPTH; e++) if (ent_cnt[e] != 1) bad++;
        check(bad == 0, "R9", "slots/entries not held exactly once", bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NLB; i++) begin
            bm_in_buf[i] = (i >= SLOTS);
            bm_loc[i]    = (i >= SLOTS) ? i - SLOTS : i;
        end
        check(req_ready && !mem_rd_en && !mem_wr_en && !done_valid, "R1",
              "idle outputs after reset", {req_ready, mem_rd_en, mem_wr_en, done_valid}, 8);
        sweep("R1");
    endtask

    task automatic t_miss(input int lb);
        int s, v, ent;
        s = bm_loc[lb];
        @(negedge clk);
        req_valid = 1'b1; req_lblk = LBW'(lb);
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_rd_en && !mem_wr_en, "R3", "read cycle rd/wr", {mem_rd_en, mem_wr_en}, 2);
        check(int'(mem_slot) == s, "R3", "read slot", mem_slot, s);
        check(!req_ready, "R6", "ready during read", req_ready, 0);
        @(negedge clk);
        check(mem_wr_en && !mem_rd_en, "R3", "write cycle rd/wr", {mem_rd_en, mem_wr_en}, 1);
        check(int'(mem_slot) == s, "R3", "write slot", mem_slot, s);
        check(done_valid && !done_hit, "R3", "done on miss", {done_valid, done_hit}, 2);
        check(!req_ready, "R6", "ready during write", req_ready, 0);
        v = int'(mem_wr_lblk);
        check(v < NLB && bm_in_buf[v], "R4", "victim was buffered", v, -1);
        check(v != lb, "R4", "victim differs from request", v, lb);
        ent = (v < NLB) ? bm_loc[v] : -1;
        check(ent != last_ent, "R4", "victim entry vs last filled", ent, last_ent);
        if (v < NLB) begin
            bm_in_buf[v] = 1'b0; bm_loc[v] = s;
            bm_in_buf[lb] = 1'b1; bm_loc[lb] = ent;
            used_ent[ent] = 1'b1;
            last_ent = ent;
        end
        @(negedge clk);
        check(req_ready, "R6", "ready back after miss", req_ready, 1);
        lk_lblk = LBW'(lb); #0.5;
        check(lk_in_buf && int'(lk_loc) == ent, "R5", "requested block location",
              lk_loc, ent);
        lk_lblk = LBW'(v); #0.5;
        check(!lk_in_buf && int'(lk_loc) == s, "R5", "victim block location", lk_loc, s);
    endtask

    task automatic t_hit(input int lb);
        int loc;
        loc = bm_loc[lb];
        @(negedge clk);
        req_valid = 1'b1; req_lblk = LBW'(lb);
        @(negedge clk);
        req_valid = 1'b0;
        check(done_valid && done_hit, "R2", "hit response", {done_valid, done_hit}, 3);
        check(!mem_rd_en && !mem_wr_en, "R2", "no bus traffic on hit",
              {mem_rd_en, mem_wr_en}, 0);
        check(!req_ready, "R6", "ready during hit", req_ready, 0);
        @(negedge clk);
        check(!mem_rd_en && !mem_wr_en && req_ready, "R2", "quiet after hit",
              {mem_rd_en, mem_wr_en, req_ready}, 1);
        lk_lblk = LBW'(lb); #0.5;
        check(lk_in_buf && int'(lk_loc) == loc, "R2", "hit block not moved", lk_loc, loc);
    endtask

    task automatic t_oob(input int lb);
        int quiet;
        quiet = 1;
        @(negedge clk);
        req_valid = 1'b1; req_lblk = LBW'(lb);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (mem_rd_en || mem_wr_en || done_valid || !req_ready) quiet = 0;
            @(negedge clk);
        end
        check(quiet == 1, "R7", "out-of-range request dropped", quiet, 1);
    endtask

    function automatic int pick_mem(input int start);
        for (int k = 0; k < NLB; k++) begin
            int c;
            c = (start + k) % NLB;
            if (!bm_in_buf[c]) return c;
        end
        return 0;
    endfunction

    task automatic t_random_run();
        int distinct;
        for (int e = 0; e < DEPTH; e++) used_ent[e] = 1'b0;
        for (int k = 0; k < 40; k++) t_miss(pick_mem(k * 7));
        distinct = 0;
        for (int e = 0; e < DEPTH; e++) if (used_ent[e]) distinct++;
        check(distinct >= 3, "R10", "distinct victim entries", distinct, 3);
        sweep("R5");
    endtask

    initial begin
        int v;
        t_reset();
        t_hit(SLOTS + 2);
        t_miss(0);
        t_miss(5);
        t_hit(5);
        t_hit(0);
        sweep("R5");
        // re-request a block just written back: it must be read from its new slot
        v = -1;
        for (int i = SLOTS; i < NLB; i++) if (!bm_in_buf[i] && v < 0) v = i;
        if (v >= 0) t_miss(v);
        t_oob(NLB);
        t_oob((1 << LBW) - 1);
        t_random_run();
        summary();
    end

endmodule